// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches the transmit-side data stream of a line interface, taken as two rails (positive and negative pulse), with one sample per bit interval marked by a strobe. It raises a loss-of-signal status once the line has stayed silent for long enough. It drops that status again only after the line has carried enough pulses over a qualifying window. The silence limit, the window length and the zero-run cap all depend on the line mode (T1/J1 or E1) and on a criterion-select input.

Around the status bit, the block keeps a sticky interrupt flag. The flag can be set on the rising edge of the status only, or on both edges, and is cleared by a write-one-to-clear strobe. The interrupt output is the flag gated by a mask input. A one-cycle event pulse on each new loss feeds an external error counter or indicator. Detection runs only while the input format selects one of the two dual-rail formats. In any other format the status is held low and all counters stay at zero.

Top module: `line_los_monitor`

## Requirements
- R1: `fmtSel` codes 1 (dual-rail NRZ) and 2 (dual-rail RZ) enable detection. Codes 0 and 3 force `losStatus` low and hold all interval counters at zero, so a stream of any length has no effect.
- R2: With `losStatus` low, the status goes high at the clock edge that takes the N-th consecutive zero sample. N is 175 when `lineE1`=0 and `critSel`=0, 1544 when `lineE1`=0 and `critSel`=1, 32 when `lineE1`=1 and `critSel`=0, and 2048 when `lineE1`=1 and `critSel`=1. At the same edge `losEvent` goes high for exactly one cycle.
- R3: A sample counts as a mark when `posRail` or `negRail` (or both) is 1.
- R4: With `losStatus` high, a clearing window opens only on a mark sample and spans M samples (M=175 when `lineE1`=0, M=32 when `lineE1`=1). The status goes low at the edge that takes the M-th sample if the window holds at least ceil(M/8) marks (22 or 4). Otherwise the window closes and the next mark opens a new one.
- R5: A window in which a run of zeros reaches 100 samples (`lineE1`=0) or 16 samples (`lineE1`=1) is abandoned at once and cannot clear the status. A run one sample shorter is allowed.
- R6: With `edgeAny`=0, `intStatus` is set one cycle after `losStatus` rises. A falling status leaves it unchanged.
- R7: With `edgeAny`=1, `intStatus` is set one cycle after either a rise or a fall of `losStatus`.
- R8: `intOut` is high exactly when `intStatus` is 1 and `intMask` is 0.
- R9: A one-cycle `intClr` clears `intStatus`. When a set condition and `intClr` fall in the same cycle, `intStatus` ends up 1.
- R10: After reset, `losStatus`, `intStatus`, `intOut` and `losEvent` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | One pulse per bit interval; rails are sampled when high |
| posRail | input | 1 | Positive-rail pulse for this interval |
| negRail | input | 1 | Negative-rail pulse for this interval |
| fmtSel | input | 2 | Input format: 0 single-rail, 1 dual-rail NRZ, 2 dual-rail RZ, 3 other |
| lineE1 | input | 1 | 0 selects T1/J1 thresholds, 1 selects E1 thresholds |
| critSel | input | 1 | Picks the short or long declare limit |
| edgeAny | input | 1 | 0: interrupt on rising status only; 1: on either edge |
| intMask | input | 1 | Masks `intOut` when 1 |
| intClr | input | 1 | Write-one-to-clear strobe for `intStatus` |
| losStatus | output | 1 | Loss-of-signal status |
| intStatus | output | 1 | Sticky interrupt flag |
| intOut | output | 1 | Interrupt request |
| losEvent | output | 1 | One-cycle pulse per declared loss |

## Verification
The edge detector's set condition and the software clear strobe can land in the same cycle, and only the set condition may survive. The bench provokes this by driving `intClr` during the cycle right after the declaring edge, when the status rise is being seen. It then checks that `intStatus` reads 1 afterwards. It also asserts `intClr` alone, with no edge pending, to confirm that the clear works when it has no competitor.

// File: rtl/llm_pkg.sv
package llm_pkg;
  // Strobes from the control to the window datapath
  typedef struct packed {
    logic start;    // open a window on this (mark) sample
    logic advance;  // count this sample into the open window
  } winCtl_t;

  typedef enum logic [1:0] {
    FMT_SINGLE   = 2'd0,
    FMT_DUAL_NRZ = 2'd1,
    FMT_DUAL_RZ  = 2'd2,
    FMT_OTHER    = 2'd3
  } fmt_e;
endpackage

// File: rtl/llm_datapath.sv
module llm_datapath import llm_pkg::*; #(
  parameter int T1_DECL_SHORT = 175,
  parameter int T1_DECL_LONG  = 1544,
  parameter int E1_DECL_SHORT = 32,
  parameter int E1_DECL_LONG  = 2048,
  parameter int T1_WIN        = 175,
  parameter int E1_WIN        = 32,
  parameter int T1_ZCAP       = 100,
  parameter int E1_ZCAP       = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    en,
  input  logic    sampleEn,
  input  logic    mark,
  input  logic    lineE1,
  input  logic    critSel,
  input  winCtl_t ctl,
  output logic    zeroHitN,
  output logic    zeroBreak,
  output logic    winLast,
  output logic    densityOk
);
  localparam int MAXD1 = (T1_DECL_SHORT > T1_DECL_LONG) ? T1_DECL_SHORT : T1_DECL_LONG;
  localparam int MAXD2 = (E1_DECL_SHORT > E1_DECL_LONG) ? E1_DECL_SHORT : E1_DECL_LONG;
  localparam int MAXD  = (MAXD1 > MAXD2) ? MAXD1 : MAXD2;
  localparam int ZW    = $clog2(MAXD + 1);
  localparam int ZW1   = ZW + 1;
  localparam int MAXW  = (T1_WIN > E1_WIN) ? T1_WIN : E1_WIN;
  localparam int WW    = $clog2(MAXW + 1);
  localparam int T1_NEED = (T1_WIN + 7) / 8;
  localparam int E1_NEED = (E1_WIN + 7) / 8;

  logic [ZW-1:0]  zeroRun;
  logic [ZW1-1:0] zeroNext, declLimit, zeroCap;
  logic [WW-1:0]  winCnt, markCnt, winLen, needMarks, markNext;

  always_comb begin
    unique case ({lineE1, critSel})
      2'b00:   declLimit = ZW1'(T1_DECL_SHORT);
      2'b01:   declLimit = ZW1'(T1_DECL_LONG);
      2'b10:   declLimit = ZW1'(E1_DECL_SHORT);
      default: declLimit = ZW1'(E1_DECL_LONG);
    endcase
    zeroCap   = lineE1 ? ZW1'(E1_ZCAP) : ZW1'(T1_ZCAP);
    winLen    = lineE1 ? WW'(E1_WIN)   : WW'(T1_WIN);
    needMarks = lineE1 ? WW'(E1_NEED)  : WW'(T1_NEED);
    zeroNext  = {1'b0, zeroRun} + ZW1'(1);
    markNext  = markCnt + WW'(mark);
    zeroHitN  = !mark && (zeroNext >= declLimit);
    zeroBreak = !mark && (zeroNext >= zeroCap);
    winLast   = (winCnt + WW'(1)) == winLen;
    densityOk = markNext >= needMarks;
  end

  // Consecutive-zero counter shared by declare and zero-run cap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              zeroRun <= '0;
    else if (!en)           zeroRun <= '0;
    else if (sampleEn) begin
      if (mark)             zeroRun <= '0;
      else if (zeroRun != '1) zeroRun <= zeroRun + ZW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      markCnt <= '0;
    end else if (!en) begin
      winCnt  <= '0;
      markCnt <= '0;
    end else if (ctl.start) begin
      winCnt  <= WW'(1);
      markCnt <= WW'(1);
    end else if (ctl.advance) begin
      winCnt  <= winCnt + WW'(1);
      markCnt <= markNext;
    end
  end

  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WW'(MAXW));

  // R1
  idle_counters_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (zeroRun == '0) && (winCnt == '0));
endmodule

// File: rtl/llm_control.sv
module llm_control import llm_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    en,
  input  logic    sampleEn,
  input  logic    mark,
  input  logic    zeroHitN,
  input  logic    zeroBreak,
  input  logic    winLast,
  input  logic    densityOk,
  input  logic    edgeAny,
  input  logic    intMask,
  input  logic    intClr,
  output winCtl_t ctl,
  output logic    lost,
  output logic    losEvent,
  output logic    intStatus,
  output logic    intOut
);
  logic winActive, lostPrev, sample, setEv;

  always_comb begin
    sample      = en && sampleEn;
    ctl.start   = sample && lost && !winActive && mark;
    ctl.advance = sample && lost && winActive;
    setEv       = edgeAny ? (lost != lostPrev) : (lost && !lostPrev);
    intOut      = intStatus && !intMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lost      <= 1'b0;
      winActive <= 1'b0;
      losEvent  <= 1'b0;
    end else begin
      losEvent <= 1'b0;
      if (!en) begin
        lost      <= 1'b0;
        winActive <= 1'b0;
      end else if (sample) begin
        if (!lost) begin
          winActive <= 1'b0;
          if (zeroHitN) begin
            lost     <= 1'b1;
            losEvent <= 1'b1;
          end
        end else if (!winActive) begin
          if (mark) winActive <= 1'b1;
        end else if (zeroBreak) begin
          winActive <= 1'b0;
        end else if (winLast) begin
          winActive <= 1'b0;
          if (densityOk) lost <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lostPrev  <= 1'b0;
      intStatus <= 1'b0;
    end else begin
      lostPrev <= lost;
      if (setEv)       intStatus <= 1'b1;
      else if (intClr) intStatus <= 1'b0;
    end
  end

  // R2
  evt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    losEvent |=> !losEvent);

  // R2
  evt_with_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    losEvent |-> lost);

  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !lost);

  // R4
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lost) && $past(en)) |-> $past(winLast && densityOk && winActive));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lost && !lostPrev) |=> intStatus);
endmodule

// File: rtl/line_los_monitor.sv
module line_los_monitor import llm_pkg::*; #(
  parameter int T1_DECL_SHORT = 175,
  parameter int T1_DECL_LONG  = 1544,
  parameter int E1_DECL_SHORT = 32,
  parameter int E1_DECL_LONG  = 2048,
  parameter int T1_WIN        = 175,
  parameter int E1_WIN        = 32,
  parameter int T1_ZCAP       = 100,
  parameter int E1_ZCAP       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       posRail,
  input  logic       negRail,
  input  logic [1:0] fmtSel,
  input  logic       lineE1,
  input  logic       critSel,
  input  logic       edgeAny,
  input  logic       intMask,
  input  logic       intClr,
  output logic       losStatus,
  output logic       intStatus,
  output logic       intOut,
  output logic       losEvent
);
  logic    en, mark, zeroHitN, zeroBreak, winLast, densityOk;
  winCtl_t ctl;

  assign en   = (fmtSel == FMT_DUAL_NRZ) || (fmtSel == FMT_DUAL_RZ);
  assign mark = posRail || negRail;

  llm_datapath #(
    .T1_DECL_SHORT(T1_DECL_SHORT), .T1_DECL_LONG(T1_DECL_LONG),
    .E1_DECL_SHORT(E1_DECL_SHORT), .E1_DECL_LONG(E1_DECL_LONG),
    .T1_WIN(T1_WIN), .E1_WIN(E1_WIN), .T1_ZCAP(T1_ZCAP), .E1_ZCAP(E1_ZCAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .en(en), .sampleEn(sampleEn), .mark(mark),
    .lineE1(lineE1), .critSel(critSel), .ctl(ctl),
    .zeroHitN(zeroHitN), .zeroBreak(zeroBreak), .winLast(winLast),
    .densityOk(densityOk)
  );

  llm_control u_ctl (
    .clk(clk), .rstN(rstN), .en(en), .sampleEn(sampleEn), .mark(mark),
    .zeroHitN(zeroHitN), .zeroBreak(zeroBreak), .winLast(winLast),
    .densityOk(densityOk), .edgeAny(edgeAny), .intMask(intMask),
    .intClr(intClr), .ctl(ctl), .lost(losStatus), .losEvent(losEvent),
    .intStatus(intStatus), .intOut(intOut)
  );
endmodule

// File: tb/line_los_monitor_bench.sv
module line_los_monitor_bench;
  logic clk = 1'b0;
  logic rstN, sampleEn, posRail, negRail, lineE1, critSel;
  logic edgeAny, intMask, intClr;
  logic [1:0] fmtSel;
  logic losStatus, intStatus, intOut, losEvent;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  line_los_monitor u_line_los_monitor (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .posRail(posRail),
    .negRail(negRail), .fmtSel(fmtSel), .lineE1(lineE1), .critSel(critSel),
    .edgeAny(edgeAny), .intMask(intMask), .intClr(intClr),
    .losStatus(losStatus), .intStatus(intStatus), .intOut(intOut),
    .losEvent(losEvent)
  );

  // {lineE1, critSel, declare length N}
  typedef struct packed { logic e1; logic crit; int n; } declVec_t;
  localparam declVec_t DECL_TABLE [4] = '{
    '{1'b0, 1'b0, 175}, '{1'b0, 1'b1, 1544},
    '{1'b1, 1'b0, 32},  '{1'b1, 1'b1, 2048}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic feed(input logic p, input logic n);
    posRail = p; negRail = n; sampleEn = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic zeros(input int len);
    for (int i = 0; i < len; i++) feed(1'b0, 1'b0);
  endtask

  // Marks (negative rail) at four listed positions of a len-sample stretch
  task automatic feed4(input int len, input int a, input int b, input int c, input int d);
    for (int i = 0; i < len; i++) begin
      if (i == a || i == b || i == c || i == d) feed(1'b0, 1'b1);
      else feed(1'b0, 1'b0);
    end
  endtask

  // Marks every stride samples, skipping one position; rail alternates
  task automatic feedStride(input int len, input int stride, input int skipAt);
    for (int i = 0; i < len; i++) begin
      if (i % stride == 0 && i != skipAt) feed(i % 16 == 0, i % 16 != 0);
      else feed(1'b0, 1'b0);
    end
  endtask

  task automatic doReset(input logic e1, input logic crit);
    rstN = 1'b0; sampleEn = 1'b0; posRail = 1'b0; negRail = 1'b0;
    fmtSel = 2'd1; lineE1 = e1; critSel = crit;
    edgeAny = 1'b0; intMask = 1'b0; intClr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset(1'b1, 1'b0);
    // R10 reset state
    chk("R10 status", losStatus, 1'b0);
    chk("R10 intStatus", intStatus, 1'b0);
    chk("R10 intOut", intOut, 1'b0);
    chk("R10 event", losEvent, 1'b0);

    // R2 declare threshold per mode and criterion
    foreach (DECL_TABLE[k]) begin
      doReset(DECL_TABLE[k].e1, DECL_TABLE[k].crit);
      zeros(DECL_TABLE[k].n - 1);
      chk("R2 before N", losStatus, 1'b0);
      feed(1'b0, 1'b0);
      chk("R2 at N", losStatus, 1'b1);
      chk("R2 event pulse", losEvent, 1'b1);
      feed(1'b0, 1'b0);
      chk("R2 event one cycle", losEvent, 1'b0);
    end

    // R3 positive rail alone resets the zero run
    doReset(1'b1, 1'b0);
    zeros(31); feed(1'b1, 1'b0); zeros(31);
    chk("R3 pos rail mark", losStatus, 1'b0);

    // R4 E1 clear with 4 marks in 32, negative rail only (R3)
    doReset(1'b1, 1'b0); zeros(32);
    feed4(31, 0, 8, 16, 24);
    chk("R4 before M", losStatus, 1'b1);
    feed(1'b0, 1'b0);
    chk("R4 clear at M", losStatus, 1'b0);

    // R4 three marks is not enough
    doReset(1'b1, 1'b0); zeros(32);
    feed4(32, 0, 8, 16, 999);
    chk("R4 low density", losStatus, 1'b1);

    // R4 window opens on a mark, not on leading zeros
    doReset(1'b1, 1'b0); zeros(32);
    zeros(3); feed4(31, 0, 8, 16, 24);
    chk("R4 start on mark", losStatus, 1'b1);
    feed(1'b0, 1'b0);
    chk("R4 clear after mark window", losStatus, 1'b0);

    // R5 a run of 15 zeros is allowed
    doReset(1'b1, 1'b0); zeros(32);
    feed4(31, 0, 16, 24, 28);
    feed(1'b0, 1'b0);
    chk("R5 run 15 ok", losStatus, 1'b0);

    // R5 a run of 16 zeros abandons the window
    doReset(1'b1, 1'b0); zeros(32);
    feed4(32, 0, 17, 25, 29);
    chk("R5 run 16 abandons", losStatus, 1'b1);

    // R4 T1: 22 marks in 175 clears, 21 does not
    doReset(1'b0, 1'b0); zeros(175);
    feedStride(174, 8, -1);
    chk("R4 T1 before M", losStatus, 1'b1);
    feed(1'b0, 1'b0);
    chk("R4 T1 clear", losStatus, 1'b0);
    doReset(1'b0, 1'b0); zeros(175);
    feedStride(175, 8, 168);
    chk("R4 T1 21 marks", losStatus, 1'b1);

    // R6 rising-only interrupt, R8 mask, R9 clear
    doReset(1'b1, 1'b0); zeros(32);
    chk("R6 lag", intStatus, 1'b0);
    feed(1'b0, 1'b0);
    chk("R6 set on rise", intStatus, 1'b1);
    chk("R8 intOut unmasked", intOut, 1'b1);
    intMask = 1'b1; #1;
    chk("R8 intOut masked", intOut, 1'b0);
    intMask = 1'b0; #1;
    chk("R8 intOut unmasked again", intOut, 1'b1);
    intClr = 1'b1; feed(1'b0, 1'b0); intClr = 1'b0;
    chk("R9 clear strobe", intStatus, 1'b0);
    feed4(31, 0, 8, 16, 24); feed(1'b0, 1'b0);
    chk("R6 status fell", losStatus, 1'b0);
    feed(1'b0, 1'b0);
    chk("R6 fall ignored", intStatus, 1'b0);

    // R7 any-edge interrupt
    doReset(1'b1, 1'b0); edgeAny = 1'b1; zeros(32); feed(1'b0, 1'b0);
    chk("R7 set on rise", intStatus, 1'b1);
    intClr = 1'b1; feed(1'b0, 1'b0); intClr = 1'b0;
    feed4(31, 0, 8, 16, 24); feed(1'b0, 1'b0);
    chk("R7 pre-fall", intStatus, 1'b0);
    feed(1'b0, 1'b0);
    chk("R7 set on fall", intStatus, 1'b1);

    // R9 set event beats clear strobe in the same cycle
    doReset(1'b1, 1'b0); zeros(32);
    intClr = 1'b1; feed(1'b0, 1'b0); intClr = 1'b0;
    chk("R9 set wins", intStatus, 1'b1);

    // R1 format gating
    doReset(1'b1, 1'b0); fmtSel = 2'd0; zeros(40);
    chk("R1 single rail idle", losStatus, 1'b0);
    fmtSel = 2'd3; zeros(40);
    chk("R1 other format idle", losStatus, 1'b0);
    fmtSel = 2'd2; zeros(31);
    chk("R1 counters were held at zero", losStatus, 1'b0);
    feed(1'b0, 1'b0);
    chk("R1 dual RZ detects", losStatus, 1'b1);
    fmtSel = 2'd0; feed(1'b0, 1'b0);
    chk("R1 disable drops status", losStatus, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule